// File: doc/BRIEF.md
# Blocking Write-Back Data Cache Controller

This block is a direct-mapped data cache between a processor and a slow block-wide main memory. It keeps a tag, a valid flag, a dirty flag and a four-word data block for each of 1024 lines, which gives 16 KB in all. A four-state machine sequences it. Stores that hit change only the cached copy and mark the line dirty. A dirty line reaches memory only when a later access to a different address evicts it.

The processor raises a request with a read/write flag, a word-aligned 32-bit byte address and write data. It holds the request until the cache pulses its ready output, and it issues nothing else in between. On a miss, the controller first writes out a dirty victim block as one 128-bit transfer. It then reads the missing block as one 128-bit transfer and re-runs the tag compare, which now hits. Each memory transfer lasts until the memory raises its ready for one cycle.

Top module: `wbc_cache`

## Requirements
- R1: While reset is high and in the cycle after it, cpu_ready and mem_valid are low. Reset marks every line invalid and clean, so the first access to any address afterwards reads from memory and writes nothing back, even if that line was dirty before the reset.
- R2: An address splits into tag = bits 31..14, line index = bits 13..4 and word select = bits 3..2. Word 0 sits in block bits 31..0 and word 3 in bits 127..96. Memory addresses always have bits 3..0 at zero.
- R3: A read hit returns the selected word on cpu_rdata with cpu_ready high in the first cycle after the request is accepted, and it causes no memory transfer.
- R4: A write hit replaces only the selected word, marks the line dirty and causes no memory transfer. A later read of that word returns the written value.
- R5: A miss on an invalid or clean line makes exactly one memory read, with mem_we low, at the requested address with bits 3..0 cleared. The access then completes as a hit on the new block.
- R6: A miss on a valid dirty line first makes one memory write, with mem_we high, of the whole old block to {old tag, index, 4'b0000}. The read of the new block follows.
- R7: A write miss fetches the block first (write-allocate), then writes the word into it and marks the line dirty.
- R8: Once mem_valid is raised, mem_valid, mem_we and mem_addr stay unchanged until the cycle in which mem_ready is high.
- R9: Processor addresses are word-aligned (bits 1..0 zero) whenever cpu_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when cpu_ready is high |
| cpu_ready | output | 1 | One-cycle pulse when the access completes |
| mem_valid | output | 1 | Block transfer requested |
| mem_we | output | 1 | 1 = block write-back, 0 = block read |
| mem_addr | output | 32 | Block address, bits 3..0 zero |
| mem_wdata | output | 128 | Victim block for write-back |
| mem_rdata | input | 128 | Fetched block, taken when mem_ready is high |
| mem_ready | input | 1 | Memory completes the current transfer |

## Verification
A wrong internal state shows up at the ports in a small number of accesses. A lost dirty flag shows up one conflicting access later: no write-back appears on the memory side, and a later reread of the evicted word returns stale data. A wrong stored tag turns a hit into an extra memory read, or makes a miss return the wrong block, in the same access. A wrong word select corrupts cpu_rdata in the very next read of that block. Each access is checked for its read-out data and for the number and addresses of the block reads and writes it causes, against a line model kept in the bench.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;
    localparam int WORDS  = 4;
    localparam int IDX_W  = 10;
    localparam int SEL_W  = $clog2(WORDS);
    localparam int OFS_W  = SEL_W + $clog2(WORD_W / 8);
    localparam int TAG_W  = ADDR_W - IDX_W - OFS_W;
    localparam int BLK_W  = WORD_W * WORDS;
    localparam int LINES  = 1 << IDX_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMP  = 2'd1,
        ST_WB   = 2'd2,
        ST_FILL = 2'd3
    } st_t;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
        logic [SEL_W-1:0] sel;
    } waddr_t;

    typedef struct packed {
        logic              we;
        waddr_t            wa;
        logic [WORD_W-1:0] wdata;
    } req_t;

    function automatic logic [ADDR_W-1:0] blk_addr(input logic [TAG_W-1:0] t,
                                                   input logic [IDX_W-1:0] i);
        return {t, i, {OFS_W{1'b0}}};
    endfunction

    function automatic logic [WORD_W-1:0] pick_word(input logic [BLK_W-1:0] b,
                                                    input logic [SEL_W-1:0] s);
        return b[s*WORD_W +: WORD_W];
    endfunction
endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store
    import wbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             dirty_set,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty
);
    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[idx] <= fill_tag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (dirty_set) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    assign rd_tag   = tag_q[idx];
    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];

    // a freshly filled line reads back valid and clean
    assert_fill_clean_R5: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !dirty_set) |=> (rd_valid && !rd_dirty));
endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store
    import wbc_pkg::*;
(
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic              fill_en,
    input  logic [BLK_W-1:0]  fill_blk,
    input  logic              word_we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [WORD_W-1:0] word_in,
    output logic [BLK_W-1:0]  blk_out
);
    logic [BLK_W-1:0] data_q [LINES];
    logic [BLK_W-1:0] merged;

    // per-word merge, one lane per word of the block
    for (genvar w = 0; w < WORDS; w++) begin : g_lane
        assign merged[w*WORD_W +: WORD_W] =
            (word_we && sel == SEL_W'(w)) ? word_in : data_q[idx][w*WORD_W +: WORD_W];
    end

    always_ff @(posedge clk) begin
        if (fill_en)      data_q[idx] <= fill_blk;
        else if (word_we) data_q[idx] <= merged;
    end

    assign blk_out = data_q[idx];
endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
    import wbc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cpu_valid,
    input  logic req_we,
    input  logic hit,
    input  logic victim_dirty,
    input  logic mem_ready,
    output st_t  state,
    output logic accept,
    output logic done,
    output logic word_we,
    output logic fill_en,
    output logic mem_valid,
    output logic mem_we
);
    st_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cpu_valid) state_d = ST_CMP;
            ST_CMP:  state_d = hit ? ST_IDLE : (victim_dirty ? ST_WB : ST_FILL);
            ST_WB:   if (mem_ready) state_d = ST_FILL;
            ST_FILL: if (mem_ready) state_d = ST_CMP;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state     = state_q;
    assign accept    = (state_q == ST_IDLE) && cpu_valid;
    assign done      = (state_q == ST_CMP) && hit;
    assign word_we   = done && req_we;
    assign fill_en   = (state_q == ST_FILL) && mem_ready;
    assign mem_valid = (state_q == ST_WB) || (state_q == ST_FILL);
    assign mem_we    = (state_q == ST_WB);

    // a finished write-back is always followed by a block read
    assert_wb_then_read_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && mem_we) |=> (mem_valid && !mem_we));

    // an access that completes never overlaps a memory transfer
    assert_done_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_valid);
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
    import wbc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_valid,
    input  logic               cpu_we,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [WORD_W-1:0]  cpu_wdata,
    output logic [WORD_W-1:0]  cpu_rdata,
    output logic               cpu_ready,
    output logic               mem_valid,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [BLK_W-1:0]   mem_wdata,
    input  logic [BLK_W-1:0]   mem_rdata,
    input  logic               mem_ready
);
    req_t             req_q;
    st_t              state;
    logic             accept, done, word_we, fill_en;
    logic [TAG_W-1:0] rd_tag;
    logic             rd_valid, rd_dirty, hit;
    logic [BLK_W-1:0] blk;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (accept) begin
            req_q.we    <= cpu_we;
            req_q.wa    <= cpu_addr[ADDR_W-1 -: TAG_W+IDX_W+SEL_W];
            req_q.wdata <= cpu_wdata;
        end
    end

    assign hit = rd_valid && (rd_tag == req_q.wa.tag);

    wbc_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cpu_valid    (cpu_valid),
        .req_we       (req_q.we),
        .hit          (hit),
        .victim_dirty (rd_valid && rd_dirty),
        .mem_ready    (mem_ready),
        .state        (state),
        .accept       (accept),
        .done         (done),
        .word_we      (word_we),
        .fill_en      (fill_en),
        .mem_valid    (mem_valid),
        .mem_we       (mem_we)
    );

    wbc_tag_store u_tags (
        .clk       (clk),
        .rst       (rst),
        .idx       (req_q.wa.idx),
        .fill_en   (fill_en),
        .fill_tag  (req_q.wa.tag),
        .dirty_set (word_we),
        .rd_tag    (rd_tag),
        .rd_valid  (rd_valid),
        .rd_dirty  (rd_dirty)
    );

    wbc_data_store u_data (
        .clk      (clk),
        .idx      (req_q.wa.idx),
        .fill_en  (fill_en),
        .fill_blk (mem_rdata),
        .word_we  (word_we),
        .sel      (req_q.wa.sel),
        .word_in  (req_q.wdata),
        .blk_out  (blk)
    );

    assign mem_addr  = (state == ST_WB) ? blk_addr(rd_tag, req_q.wa.idx)
                                        : blk_addr(req_q.wa.tag, req_q.wa.idx);
    assign mem_wdata = blk;
    assign cpu_rdata = pick_word(blk, req_q.wa.sel);
    assign cpu_ready = done;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!cpu_ready && !mem_valid));

    assert_req_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_we) && $stable(mem_addr)));

    assert_refill_hits_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && !mem_we) |=> cpu_ready);

    assert_dirty_evicts_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CMP && !hit && rd_valid && rd_dirty) |=> (mem_valid && mem_we));

    assert_blk_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_addr[OFS_W-1:0] == '0));

    assert_word_aligned_R9: assert property (@(posedge clk) disable iff (rst)
        cpu_valid |-> (cpu_addr[OFS_W-SEL_W-1:0] == '0));
endmodule

// File: tb/wbc_cache_tb.sv
module wbc_cache_tb;
    localparam int LAT = 3;
    localparam int NV  = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cpu_valid = 1'b0, cpu_we = 1'b0;
    logic [31:0]  cpu_addr = '0, cpu_wdata = '0;
    logic [31:0]  cpu_rdata;
    logic         cpu_ready, mem_valid, mem_we;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [127:0] mem_rdata = '0;
    logic         mem_ready = 1'b0;

    int checks = 0, errors = 0, cycles = 0;
    int nrd = 0, nwr = 0, unstable = 0;
    logic [31:0] last_rd_addr = '0, last_wr_addr = '0;

    logic [127:0] mblk [bit [27:0]];
    logic [31:0]  shw  [bit [29:0]];
    logic [17:0]  rtag   [1024];
    logic         rvalid [1024];
    logic         rdirty [1024];

    // {we, addr, wdata}
    localparam logic [64:0] VEC [NV] = '{
        {1'b0, 32'h0000_1000, 32'h0},
        {1'b0, 32'h0000_1004, 32'h0},
        {1'b1, 32'h0000_1008, 32'h1111_1111},
        {1'b0, 32'h0000_1008, 32'h0},
        {1'b0, 32'h0000_5008, 32'h0},
        {1'b0, 32'h0000_1008, 32'h0},
        {1'b1, 32'h0002_0010, 32'h2222_2222},
        {1'b0, 32'h0002_0010, 32'h0},
        {1'b1, 32'h0003_0010, 32'h3333_3333},
        {1'b0, 32'h0002_001C, 32'h0},
        {1'b0, 32'h0003_0010, 32'h0},
        {1'b0, 32'hFFFF_FFFC, 32'h0}
    };

    wbc_cache u_dut (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .mem_valid(mem_valid), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'hC3A5_5A3C;
    endfunction

    function automatic logic [127:0] blk_of(input logic [27:0] b);
        logic [127:0] r;
        if (mblk.exists(b)) return mblk[b];
        for (int w = 0; w < 4; w++) r[w*32 +: 32] = pat({b, w[1:0], 2'b00});
        return r;
    endfunction

    // memory model: LAT cycles per transfer, one-cycle ready pulse
    int mcnt = 0;
    always @(posedge clk) begin
        if (rst) begin
            mem_ready <= 1'b0;
            mcnt      <= 0;
        end else if (mem_ready) begin
            mem_ready <= 1'b0;
        end else if (mem_valid) begin
            if (mcnt == LAT - 1) begin
                mcnt      <= 0;
                mem_ready <= 1'b1;
                if (mem_we) mblk[mem_addr[31:4]] = mem_wdata;
                else        mem_rdata <= blk_of(mem_addr[31:4]);
            end else begin
                mcnt <= mcnt + 1;
            end
        end
    end

    // transfer monitor and R8 stability watch
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;
    logic        pend_we = 1'b0;
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst && mem_valid) begin
            if (pend && (mem_addr != pend_addr || mem_we != pend_we)) unstable <= unstable + 1;
            if (mem_ready) begin
                pend <= 1'b0;
                if (mem_we) begin nwr <= nwr + 1; last_wr_addr <= mem_addr; end
                else        begin nrd <= nrd + 1; last_rd_addr <= mem_addr; end
            end else begin
                pend <= 1'b1; pend_addr <= mem_addr; pend_we <= mem_we;
            end
        end else if (!mem_valid && pend) begin
            unstable <= unstable + 1;
            pend <= 1'b0;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int waits);
        @(negedge clk);
        nrd = 0; nwr = 0;
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        waits = 0;
        do begin
            @(negedge clk);
            waits++;
        end while (!cpu_ready && waits < 200);
        rd = cpu_rdata;
        cpu_valid = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        int waits;
        for (int i = 0; i < 1024; i++) begin rvalid[i] = 1'b0; rdirty[i] = 1'b0; rtag[i] = '0; end
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check("R1", "ready in reset", {31'b0, cpu_ready}, 32'd0);
        check("R1", "mem_valid in reset", {31'b0, mem_valid}, 32'd0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R1", "mem_valid idle", {31'b0, mem_valid}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            logic        we;
            logic [31:0] a, d, expd;
            logic [9:0]  ix;
            logic [17:0] tg;
            logic        exp_rd, exp_wr;
            logic [31:0] exp_wr_addr;
            string       tag;
            we = VEC[v][64]; a = VEC[v][63:32]; d = VEC[v][31:0];
            ix = a[13:4]; tg = a[31:14];
            exp_rd = !(rvalid[ix] && rtag[ix] == tg);
            exp_wr = exp_rd && rvalid[ix] && rdirty[ix];
            exp_wr_addr = {rtag[ix], ix, 4'b0};
            if (exp_wr)      tag = "R6";
            else if (exp_rd) tag = we ? "R7" : "R5";
            else             tag = we ? "R4" : "R3";
            expd = shw.exists(a[31:2]) ? shw[a[31:2]] : pat(a);
            access(we, a, d, rd, waits);
            check(tag, "block reads", nrd, {31'b0, exp_rd});
            check(tag, "block writes", nwr, {31'b0, exp_wr});
            if (exp_rd) check("R2", "read address", last_rd_addr, {a[31:4], 4'b0});
            if (exp_wr) check("R6", "write-back address", last_wr_addr, exp_wr_addr);
            if (!we)    check(tag, "read data", rd, expd);
            if (!exp_rd) check("R3", "hit latency", waits, 32'd1);
            rvalid[ix] = 1'b1; rtag[ix] = tg;
            if (exp_rd) rdirty[ix] = 1'b0;
            if (we) begin rdirty[ix] = 1'b1; shw[a[31:2]] = d; end
        end

        // R4: a write hit leaves the neighbouring words untouched
        access(1'b0, 32'h0000_100C, 32'h0, rd, waits);
        check("R4", "neighbour word", rd, pat(32'h0000_100C));
        check("R4", "no traffic", nrd + nwr, 32'd0);

        // R7: write miss to a fresh line, then R1: reset drops the dirty data
        access(1'b1, 32'h0004_0020, 32'hDEAD_BEEF, rd, waits);
        check("R7", "allocate read", nrd, 32'd1);
        access(1'b0, 32'h0004_0020, 32'h0, rd, waits);
        check("R7", "written word", rd, 32'hDEAD_BEEF);
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
        access(1'b0, 32'h0004_0020, 32'h0, rd, waits);
        check("R1", "read after reset", nrd, 32'd1);
        check("R1", "no write-back after reset", nwr, 32'd0);
        check("R1", "memory copy", rd, pat(32'h0004_0020));

        check("R8", "request changes before ready", unstable, 32'd0);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule